// File: doc/BRIEF.md
# Serial-clock to LED one-wire pulse shaper

This block converts the clock and data lines of an external SPI master into the pulse-width-coded single-wire stream used by chained smart RGB LEDs. The SPI master does the shifting and framing. Its serial clock idles high, updates data on the rising edge, and runs at the LED bit rate. The block runs on a sample clock ten times faster than that.

Each high-to-low transition of the serial clock starts a 3-bit one-shot counter. The counter steps once per sample clock from 1 up to 7, then drops back to 0 and waits for the next falling edge. A 16-entry lookup indexed by `{held_bit, count}` drives the LED line. Counts 1 to 3 are always high. Counts 4 to 6 follow the held data bit. Counts 0 and 7 are low. So a 0 gives a 3-sample-clock high pulse and a 1 gives a 6-sample-clock high pulse.

The data bit is held in an enabled register. The register is open only while the counter is idle, so the bit being shaped cannot change during its own pulse. Both inputs pass through two-flop synchronizers first.

Top module: `ws_pulse_shaper`

## Requirements
- R1: A synchronous active-high `rst` clears the counter, the held bit and both synchronizers to 0. `led_out` is low from the first clock edge with `rst` high, and no pulse is produced until the serial clock has been seen high and then falls.
- R2: A data bit of 0 produces a high pulse on `led_out` lasting exactly 3 sample-clock cycles.
- R3: A data bit of 1 produces a high pulse on `led_out` lasting exactly 6 sample-clock cycles.
- R4: `led_out` first goes high on the third rising `clk` edge after a falling `sclk_in` level is set up (two synchronizer stages plus the counter start).
- R5: Each high-to-low transition of `sclk_in` produces exactly one pulse. Holding `sclk_in` low for many cycles does not retrigger the counter.
- R6: Changes on `sdo_in` made while the counter is running do not alter the width of the pulse in progress.
- R7: With `sclk_in` idle high, `led_out` stays low. After a pulse, the counter returns to idle and `led_out` is low before the next bit starts.
- R8: The bit that is shaped is the `sdo_in` level present at the falling edge of `sclk_in`. Bytes sent MSB first decode back to the same byte from the pulse widths.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, ten times the serial bit rate |
| rst | input | 1 | Synchronous active-high reset |
| sclk_in | input | 1 | Serial clock from the SPI master, idles high |
| sdo_in | input | 1 | Serial data from the SPI master, changes on rising `sclk_in` |
| led_out | output | 1 | Pulse-width-coded LED data line |

## Verification
The assertions assume that falling edges of the serial clock are at least eight sample clocks apart. This means the one-shot finishes before the next bit arrives. They also assume that data changes only on the rising edge or some cycles after the falling edge, never together with it. The stimulus keeps to both assumptions. It holds the serial clock high for five sample clocks and low for five, and changes data at the rising edge. Deliberate disturbances are placed at least two cycles after a falling edge: data toggles, an extended low phase, and a reset in the middle of a pulse.

// File: rtl/ws_pulse_shaper.sv
module ws_pulse_shaper #(
  parameter logic [15:0] PATTERN = 16'h7E0E
) (
  input  logic clk,
  input  logic rst,
  input  logic sclk_in,
  input  logic sdo_in,
  output logic led_out
);

  logic [1:0] sclk_sync;
  logic [1:0] sdo_sync;
  logic       sclk_prev;
  logic [2:0] cnt;
  logic       bit_q;
  logic       fall;
  logic       idle;

  assign fall = sclk_prev & ~sclk_sync[1];
  assign idle = (cnt == 3'd0);

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_sync <= 2'b00;
      sdo_sync  <= 2'b00;
      sclk_prev <= 1'b0;
    end else begin
      sclk_sync <= {sclk_sync[0], sclk_in};
      sdo_sync  <= {sdo_sync[0], sdo_in};
      sclk_prev <= sclk_sync[1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      bit_q <= 1'b0;
    else if (idle)
      bit_q <= sdo_sync[1];
  end

  always_ff @(posedge clk) begin
    if (rst)
      cnt <= 3'd0;
    else if (idle)
      cnt <= fall ? 3'd1 : 3'd0;
    else if (cnt == 3'd7)
      cnt <= 3'd0;
    else
      cnt <= cnt + 3'd1;
  end

  assign led_out = PATTERN[{bit_q, cnt}];

  assert_reset_low_R1: assert property (@(posedge clk) rst |=> !led_out);

  assert_start_R4: assert property (@(posedge clk) disable iff (rst)
    (fall && idle) |=> led_out);

  assert_short_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    (cnt == 3'd3 && !bit_q) |=> !led_out);

  assert_pulse_cap_R3: assert property (@(posedge clk) disable iff (rst)
    (cnt == 3'd6) |=> !led_out);

  assert_no_retrigger_R5: assert property (@(posedge clk) disable iff (rst)
    (idle && !sclk_prev && !sclk_sync[1]) |=> !led_out);

  assert_idle_low_R7: assert property (@(posedge clk) disable iff (rst)
    (idle && !fall) |=> !led_out);

endmodule

// File: tb/sim_ws_pulse_shaper.sv
module sim_ws_pulse_shaper;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk = 1'b1;
  logic sdo = 1'b0;
  logic led;

  int n_tests = 0;
  int n_fail = 0;
  int cyc = 0;
  int run = 0;
  int rise_cyc = 0;
  int nw = 0;
  int widths [0:511];
  int rises  [0:511];
  int fall_cyc [0:511];
  int nf = 0;
  logic prev_led = 1'b0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ws_pulse_shaper u0 (.clk(clk), .rst(rst), .sclk_in(sclk), .sdo_in(sdo), .led_out(led));

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (led && !prev_led) begin rise_cyc = cyc; run = 1; end
    else if (led) run = run + 1;
    if (!led && prev_led && nw < 512) begin
      widths[nw] = run; rises[nw] = rise_cyc; nw = nw + 1;
    end
    prev_led = led;
  end

  function automatic int exp_width(input bit b);
    return b ? 6 : 3;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin @(negedge clk); #1; end
  endtask

  task automatic send_bit(input bit b, input bit toggle_low);
    tick(1);
    sclk = 1'b1; sdo = b;
    tick(5);
    sclk = 1'b0;
    if (nf < 512) begin fall_cyc[nf] = cyc; nf++; end
    if (toggle_low) begin tick(2); sdo = ~b; tick(2); end
    else tick(4);
  endtask

  task automatic send_byte(input logic [7:0] v, input string tag);
    int base = nw;
    int fbase = nf;
    for (int i = 7; i >= 0; i--) send_bit(v[i], 1'b0);
    tick(1); sclk = 1'b1; tick(12);
    check(nw - base == 8, {tag, " R5 pulse count"}, nw - base, 8);
    for (int i = 0; i < 8; i++) begin
      if (nw - base == 8) begin
        check(widths[base+i] == exp_width(v[7-i]),
              {tag, (v[7-i] ? " R3 width" : " R2 width"), " R8 bit"},
              widths[base+i], exp_width(v[7-i]));
        check(rises[base+i] - fall_cyc[fbase+i] == 3, {tag, " R4 latency"},
              rises[base+i] - fall_cyc[fbase+i], 3);
      end
    end
  endtask

  initial begin
    int base;
    int r;
    r = $urandom(32'd2718);
    tick(3);
    rst = 1'b0;
    tick(20);
    check(led == 1'b0, "R1 reset level", led, 0);
    check(nw == 0, "R7 idle no pulse", nw, 0);

    send_byte(8'h00, "zeros");
    send_byte(8'hFF, "ones");
    send_byte(8'hA5, "alt");
    send_byte(8'h01, "lsb");

    base = nw;
    tick(1); sclk = 1'b1; sdo = 1'b1; tick(5);
    sclk = 1'b0; tick(40);
    sclk = 1'b1; tick(12);
    check(nw - base == 1, "R5 long low single pulse", nw - base, 1);
    if (nw - base == 1) check(widths[base] == 6, "R5 long low width", widths[base], 6);

    base = nw;
    send_bit(1'b0, 1'b1);
    send_bit(1'b1, 1'b1);
    tick(1); sclk = 1'b1; tick(12);
    check(nw - base == 2, "R6 toggle count", nw - base, 2);
    if (nw - base == 2) begin
      check(widths[base] == 3, "R6 toggle bit0 width", widths[base], 3);
      check(widths[base+1] == 6, "R6 toggle bit1 width", widths[base+1], 6);
    end

    tick(1); sclk = 1'b1; sdo = 1'b1; tick(5);
    sclk = 1'b0; tick(4);
    check(led == 1'b1, "R1 pulse active before reset", led, 1);
    rst = 1'b1; tick(1);
    check(led == 1'b0, "R1 reset mid pulse", led, 0);
    rst = 1'b0;
    base = nw;
    tick(15);
    check(nw == base && led == 1'b0, "R1 no pulse after reset", nw - base, 0);
    sclk = 1'b1; tick(6);
    send_byte(8'h3C, "post reset");

    for (int k = 0; k < 24; k++) begin
      logic [7:0] v;
      v = 8'($urandom);
      send_byte(v, "random R8");
    end

    check(led == 1'b0, "R7 final idle", led, 0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule